// File: doc/BRIEF.md
# DMA Channel Address Generator

This block is the transfer engine of a single DMA channel. It keeps a 16-bit current address, a 16-bit current count and an 8-bit page value. From these it forms a 24-bit physical address for each transfer the bus side acknowledges, and after that transfer it steps the address up and the count down. Each write to the base address or the base count loads the base register and the matching current register together. The count holds the number of transfers minus one, so the channel always moves at least one unit and at most 65536.

A build parameter picks byte or word operation. In byte operation one page spans 64K bytes and the address counts bytes. In word operation the address and the count are in 16-bit words. The whole address moves up one bit position, page bit 0 takes no part, and one page spans 128K bytes. In both modes the address offset wraps inside its page and never carries into the page value, so a single transfer run cannot cross a page boundary.

When the transfer with a count of zero is acknowledged, the channel flags terminal count for that cycle. If auto-initialise is on, it then reloads the current address and count from their base values and stays enabled. If auto-initialise is off, it masks itself until it is told to unmask. Choosing between channels, the bus handshake and host register decoding are left to the surrounding logic.

Top module: `dma_chan_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `masked` is 1, `cur_count` is 0x0000, `tc` is 0 and `phys_addr` is 0x000000, because the current address and the page are both zero.
- R2: With WORD_MODE=0, `phys_addr` equals {page[7:0], current_address[15:0]}.
- R3: With WORD_MODE=1, `phys_addr` equals {page[7:1], current_address[15:0], 1'b0}. Page bit 0 has no effect and physical bit 0 is always 0.
- R4: An accepted transfer (`xfer_ack` high while `masked` is 0) increments the current address at the clock edge that ends the acknowledge cycle. The address wraps from 0xFFFF to 0x0000 and the page does not change.
- R5: An accepted transfer decrements `cur_count` at the same edge. `cur_count` is always visible, and a loaded count N gives N+1 transfers before terminal count.
- R6: `tc` is high, combinationally, in exactly the cycle of an accepted transfer whose current count is 0x0000. It is 0 at all other times.
- R7: With `autoinit_en` low, the terminal-count transfer sets `masked` to 1 and leaves `cur_count` at 0xFFFF. The address also steps as usual.
- R8: With `autoinit_en` high, the terminal-count transfer reloads the current address and count from the base values, and `masked` stays 0.
- R9: A `xfer_ack` pulse while `masked` is 1 is ignored: the address and the count keep their values and `tc` stays 0.
- R10: `base_addr_we` or `base_cnt_we` loads `wr_data` into both the base register and the current register. `page_we` loads `wr_data[7:0]` into the page. `unmask` clears `masked`. A register write in the same cycle as an accepted transfer takes priority over the step of that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr_we | input | 1 | Load base and current address from wr_data |
| base_cnt_we | input | 1 | Load base and current count from wr_data |
| page_we | input | 1 | Load page from wr_data[7:0] |
| wr_data | input | 16 | Write data for the three register strobes |
| unmask | input | 1 | Clear the channel mask |
| autoinit_en | input | 1 | Reload from base values at terminal count |
| xfer_ack | input | 1 | Transfer acknowledge strobe, one per transfer |
| phys_addr | output | 24 | Physical address of the current transfer |
| cur_count | output | 16 | Current count (transfers left minus one) |
| tc | output | 1 | Terminal count, high during the final transfer |
| masked | output | 1 | Channel mask; while set, acknowledges are ignored |

## Verification
The bench builds two copies of the block from the same stimulus: one with WORD_MODE=0 and one with WORD_MODE=1. The default 16-bit offset and 8-bit page widths are kept in both. Every acknowledged cycle therefore checks the byte mapping and the shifted word mapping side by side. An odd page value shows directly that page bit 0 is dropped in word mode. Starting the offset near 0xFFFF brings the in-page wrap within a few transfers, and loading small counts brings terminal count, mask-on-end, auto-initialise reload and write-over-step priority within a few dozen cycles.

// File: rtl/dma_chan_pkg.sv
// Package: dma_chan_pkg
// Shared types of the DMA channel address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_chan_pkg;

    // Operation applied to a stepping register in one cycle
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_LOAD   = 2'd1,
        STEP_NEXT   = 2'd2,
        STEP_RELOAD = 2'd3
    } step_op_e;

endpackage

// File: rtl/chan_step_reg.sv
// Module: chan_step_reg
// A base register paired with a current register that can be loaded,
// reloaded from the base value, or stepped by one (up or down, chosen by
// a parameter). The step wraps modulo 2**W.
// Assumes: only one operation per cycle, chosen by the caller's priority.
module chan_step_reg
    import dma_chan_pkg::*;
#(
    parameter int W        = 16,
    parameter bit DIR_DOWN = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_op_e     op,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] base_q,
    output logic [W-1:0] cur_q
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] stepped;

    // Stepped value of the current register, direction fixed at build time
    generate
        if (DIR_DOWN) begin : g_down
            assign stepped = cur_q - ONE;
        end else begin : g_up
            assign stepped = cur_q + ONE;
        end
    endgenerate

    // Base register: changes only on an explicit load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (op == STEP_LOAD) begin
            base_q <= load_val;
        end
    end

    // Current register: load, reload, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            case (op)
                STEP_LOAD:   cur_q <= load_val;
                STEP_RELOAD: cur_q <= base_q;
                STEP_NEXT:   cur_q <= stepped;
                default:     cur_q <= cur_q;
            endcase
        end
    end

    // R4 R5
    step_moves_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STEP_NEXT) |=> (cur_q == (DIR_DOWN ? W'($past(cur_q) - ONE)
                                                  : W'($past(cur_q) + ONE))));

    // R8
    reload_takes_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STEP_RELOAD) |=> (cur_q == $past(base_q)));

    // R10
    load_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STEP_LOAD) |=> (cur_q == base_q));

endmodule

// File: rtl/chan_phys_map.sv
// Module: chan_phys_map
// Forms the physical bus address from the page value and the in-page
// offset. Byte build: page above offset. Word build: offset moved up one
// bit, page bit 0 dropped, bus bit 0 held at zero.
// Assumes: PAGE_W >= 2.
module chan_phys_map #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0] offset,
    output logic [PHYS_W-1:0] phys
);

    // Pick the bit mapping at build time
    generate
        if (WORD_MODE) begin : g_word
            logic unused_page_lsb;
            assign unused_page_lsb = page[0];
            assign phys = {page[PAGE_W-1:1], offset, 1'b0};
        end else begin : g_byte
            assign phys = {page, offset};
        end
    endgenerate

endmodule

// File: rtl/dma_chan_addr_gen.sv
// Module: dma_chan_addr_gen
// One DMA channel's transfer engine: current/base address and count, page
// value, physical address output, terminal count, auto-initialise reload
// and self-masking at end of transfer.
// Assumes: xfer_ack is a one-cycle strobe per transfer from the bus side;
// register strobes come from a host decoder outside this block.
module dma_chan_addr_gen
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_addr_we,
    input  logic              base_cnt_we,
    input  logic              page_we,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              unmask,
    input  logic              autoinit_en,
    input  logic              xfer_ack,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [ADDR_W-1:0] cur_count,
    output logic              tc,
    output logic              masked
);

    logic              ack_live;
    logic              reload_now;
    step_op_e          addr_op;
    step_op_e          cnt_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] base_cnt;
    logic [PAGE_W-1:0] page_q;
    logic              unused_base;

    assign unused_base = |{base_addr, base_cnt};

    // Qualify the acknowledge and detect the final transfer
    always_comb begin
        ack_live   = xfer_ack && !masked;
        tc         = ack_live && (cur_count == '0);
        reload_now = tc && autoinit_en;
    end

    // Operation priority: host write, then reload, then step
    always_comb begin
        if (base_addr_we)    addr_op = STEP_LOAD;
        else if (reload_now) addr_op = STEP_RELOAD;
        else if (ack_live)   addr_op = STEP_NEXT;
        else                 addr_op = STEP_HOLD;

        if (base_cnt_we)     cnt_op = STEP_LOAD;
        else if (reload_now) cnt_op = STEP_RELOAD;
        else if (ack_live)   cnt_op = STEP_NEXT;
        else                 cnt_op = STEP_HOLD;
    end

    chan_step_reg #(.W(ADDR_W), .DIR_DOWN(1'b0)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (addr_op),
        .load_val (wr_data),
        .base_q   (base_addr),
        .cur_q    (cur_addr)
    );

    chan_step_reg #(.W(ADDR_W), .DIR_DOWN(1'b1)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (cnt_op),
        .load_val (wr_data),
        .base_q   (base_cnt),
        .cur_q    (cur_count)
    );

    // Page value: loaded by the host only, never by the offset wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (page_we) begin
            page_q <= wr_data[PAGE_W-1:0];
        end
    end

    // Channel mask: set at reset and at a non-reloading end, cleared on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked <= 1'b1;
        end else if (tc && !autoinit_en) begin
            masked <= 1'b1;
        end else if (unmask) begin
            masked <= 1'b0;
        end
    end

    chan_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_MODE(WORD_MODE)) u_map (
        .page   (page_q),
        .offset (cur_addr),
        .phys   (phys_addr)
    );

    // R6
    tc_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (xfer_ack && !masked));

    // R7
    tc_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !autoinit_en) |=> (masked && cur_count == '1));

    // R8
    autoinit_keeps_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && autoinit_en && !unmask) |=> !masked);

    // R9
    masked_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (masked && !base_cnt_we && !base_addr_we) |=> ($stable(cur_count) && $stable(cur_addr)));

    // R4
    page_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_we) |=> $stable(page_q));

endmodule

// File: tb/dma_chan_addr_gen_tb.sv
module dma_chan_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_addr_we = 1'b0;
    logic        base_cnt_we = 1'b0;
    logic        page_we = 1'b0;
    logic [15:0] wr_data = '0;
    logic        unmask = 1'b0;
    logic        autoinit_en = 1'b0;
    logic        xfer_ack = 1'b0;
    logic [23:0] phys_b, phys_w;
    logic [15:0] cnt_b, cnt_w;
    logic        tc_b, tc_w, msk_b, msk_w;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dma_chan_addr_gen #(.WORD_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .base_addr_we(base_addr_we), .base_cnt_we(base_cnt_we),
        .page_we(page_we), .wr_data(wr_data), .unmask(unmask), .autoinit_en(autoinit_en),
        .xfer_ack(xfer_ack), .phys_addr(phys_b), .cur_count(cnt_b), .tc(tc_b), .masked(msk_b));

    dma_chan_addr_gen #(.WORD_MODE(1'b1)) u_dut_word (
        .clk(clk), .rst_n(rst_n), .base_addr_we(base_addr_we), .base_cnt_we(base_cnt_we),
        .page_we(page_we), .wr_data(wr_data), .unmask(unmask), .autoinit_en(autoinit_en),
        .xfer_ack(xfer_ack), .phys_addr(phys_w), .cur_count(cnt_w), .tc(tc_w), .masked(msk_w));

    typedef struct packed {
        logic [23:0] pb;
        logic [23:0] pw;
        logic        tc;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state, kept from the requirements
    logic [15:0] m_addr, m_cnt, m_base_a, m_base_c;
    logic [7:0]  m_page;
    logic        m_mask;

    function automatic logic [23:0] byte_phys(input logic [7:0] p, input logic [15:0] a);
        return {p, a};
    endfunction

    function automatic logic [23:0] word_phys(input logic [7:0] p, input logic [15:0] a);
        return {p[7:1], a, 1'b0};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per acknowledged cycle
    always @(negedge clk) begin
        if (rst_n && xfer_ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 scoreboard empty", 32'd0, 32'd1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(phys_b == e.pb, "R2/R4 byte phys", {8'd0, phys_b}, {8'd0, e.pb});
                chk(phys_w == e.pw, "R3 word phys", {8'd0, phys_w}, {8'd0, e.pw});
                chk(tc_b == e.tc && tc_w == e.tc, "R6 tc", {30'd0, tc_w, tc_b}, {30'd0, e.tc, e.tc});
            end
        end else if (rst_n) begin
            if (tc_b || tc_w) chk(1'b0, "R6 tc without ack", {30'd0, tc_w, tc_b}, 32'd0);
        end
    end

    // Compare state visible at the ports with the model
    task automatic chk_state(input string tag);
        chk(cnt_b == m_cnt && cnt_w == m_cnt, tag, {cnt_w, cnt_b}, {m_cnt, m_cnt});
        chk(msk_b == m_mask && msk_w == m_mask, tag, {30'd0, msk_w, msk_b}, {30'd0, m_mask, m_mask});
    endtask

    // Host write; kind 0 = address, 1 = count, 2 = page
    task automatic wr(input int kind, input logic [15:0] d);
        @(posedge clk); #1;
        wr_data = d;
        base_addr_we = (kind == 0);
        base_cnt_we  = (kind == 1);
        page_we      = (kind == 2);
        @(posedge clk); #1;
        base_addr_we = 1'b0; base_cnt_we = 1'b0; page_we = 1'b0;
        if (kind == 0) begin m_addr = d; m_base_a = d; end
        if (kind == 1) begin m_cnt = d; m_base_c = d; end
        if (kind == 2) m_page = d[7:0];
    endtask

    task automatic do_unmask();
        @(posedge clk); #1; unmask = 1'b1;
        @(posedge clk); #1; unmask = 1'b0;
        m_mask = 1'b0;
    endtask

    // Driver: push the expectation, strobe the acknowledge, advance the model
    task automatic xfer(input string tag);
        exp_t e;
        logic etc;
        etc = !m_mask && (m_cnt == 16'h0000);
        e.pb = byte_phys(m_page, m_addr);
        e.pw = word_phys(m_page, m_addr);
        e.tc = etc;
        @(posedge clk); #1;
        exp_q.push_back(e);
        xfer_ack = 1'b1;
        @(posedge clk); #1;
        xfer_ack = 1'b0;
        if (!m_mask) begin
            if (etc && autoinit_en) begin
                m_addr = m_base_a; m_cnt = m_base_c;
            end else begin
                m_addr = m_addr + 16'd1; m_cnt = m_cnt - 16'd1;
                if (etc) m_mask = 1'b1;
            end
        end
        chk_state(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_addr = 0; m_cnt = 0; m_base_a = 0; m_base_c = 0; m_page = 0; m_mask = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(msk_b && msk_w, "R1 mask", {30'd0, msk_w, msk_b}, 32'd3);
        chk(cnt_b == 0 && cnt_w == 0, "R1 count", {cnt_w, cnt_b}, 32'd0);
        chk(phys_b == 0 && phys_w == 0 && !tc_b && !tc_w, "R1 phys/tc", {8'd0, phys_b}, 32'd0);

        // R9: acknowledge while masked is ignored
        wr(1, 16'h0005);
        xfer("R9 masked ack");

        // R10, R2, R3, R5, R6, R7: three transfers from an odd page
        wr(2, 16'h0035);
        wr(0, 16'h1234);
        wr(1, 16'h0002);
        chk_state("R10 count load");
        do_unmask();
        chk_state("R10 unmask");
        for (int i = 0; i < 3; i++) xfer("R5 count step");
        // R7: now masked with count 0xFFFF
        chk(cnt_b == 16'hFFFF, "R7 count after end", {16'd0, cnt_b}, 32'hFFFF);
        xfer("R9 ack after end");

        // R4: offset wraps in page without touching the page
        wr(2, 16'h0012);
        wr(0, 16'hFFFE);
        wr(1, 16'h0003);
        do_unmask();
        for (int i = 0; i < 4; i++) xfer("R4 wrap");

        // R5/R6: count 0 performs one transfer and ends at once
        wr(0, 16'h0400);
        wr(1, 16'h0000);
        do_unmask();
        xfer("R6 single transfer");

        // R8: auto-initialise reloads and stays enabled
        autoinit_en = 1'b1;
        wr(2, 16'h0080);
        wr(0, 16'h0100);
        wr(1, 16'h0001);
        do_unmask();
        for (int i = 0; i < 5; i++) xfer("R8 autoinit");
        chk(cnt_b == 16'h0001 || cnt_b == 16'h0000, "R8 count cycle", {16'd0, cnt_b}, 32'd1);

        // R10: write wins over the step in the same cycle
        autoinit_en = 1'b0;
        wr(1, 16'h0009);
        begin
            exp_t e;
            e.pb = byte_phys(m_page, m_addr);
            e.pw = word_phys(m_page, m_addr);
            e.tc = 1'b0;
            @(posedge clk); #1;
            exp_q.push_back(e);
            xfer_ack = 1'b1; base_addr_we = 1'b1; wr_data = 16'h7770;
            @(posedge clk); #1;
            xfer_ack = 1'b0; base_addr_we = 1'b0;
            m_addr = 16'h7770; m_base_a = 16'h7770; m_cnt = m_cnt - 16'd1;
            chk_state("R10 write priority count");
        end
        @(negedge clk);
        chk(phys_b == byte_phys(m_page, 16'h7770), "R10 write priority addr",
            {8'd0, phys_b}, {8'd0, byte_phys(m_page, 16'h7770)});
        xfer("R4 step after write");

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule